// File: doc/BRIEF.md
# Multichannel Shared-Memory Comb Delay

This block is the differencing (comb) stage of a multichannel decimating cascaded integrator-comb filter. Channels arrive round-robin, one sample per accepted cycle. Every channel's delay line lives in one shared synchronous memory that works as a circular queue. For each accepted sample the block reads the word stored one lap earlier, writes the new sample into the same slot, and outputs the new sample minus the old one.

The memory holds `DLY` laps of `NUM_CH` words. A single address counter wraps over those `NUM_CH*DLY` words. The read position trails the write position by exactly one full depth. Because of this, reading and writing always use the same slot, and the address sequence is purely sequential.

A slot that has not been written since reset reads as zero. Each channel's first `DLY` outputs therefore equal its input samples. The difference is one bit wider than the sample, so no input pair can overflow it. The output carries the channel index of the sample it belongs to. The result appears a fixed two clocks after the sample is accepted.

Top module: `mc_comb_delay`

## Requirements
- R1: After reset, `out_valid`, `out_ch` and `out_diff` are all zero.
- R2: A sample accepted at a clock edge (`in_valid` high) gives `out_valid` high exactly two clock edges later. In that cycle `out_ch` equals the `in_ch` that came with the sample.
- R3: `out_diff` equals the current sample minus the sample of the same channel `DLY` accepted samples earlier. Both are taken as two's complement, and the result is `DW+1` bits.
- R4: Until a channel has had `DLY` samples accepted since reset, its delayed term is zero, so `out_diff` equals the sample sign-extended.
- R5: Cycles with `in_valid` low leave the memory and the shared address untouched, so idle gaps do not shift any channel's history. The address advances by one per accepted sample and wraps after `NUM_CH*DLY` samples.
- R6: Full-scale inputs do not overflow. With `DW=12`, 2047 minus -2048 gives 4095, and -2048 minus 2047 gives -4095.
- R7: Channels are accepted in the fixed order 0, 1, …, `NUM_CH-1`, then back to 0. Each channel's difference depends only on that channel's own earlier samples.
- R8: `out_valid` is low two clocks after any cycle in which no sample was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Sample strobe |
| in_ch | input | CH_W | Channel index of the sample |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | Difference strobe |
| out_ch | output | CH_W | Channel index of the difference |
| out_diff | output | DW+1 | Signed difference, current minus delayed |

## Verification
The block has two register stages. The first holds the sample together with the memory's registered read word, and the second holds the difference. Every result is therefore due at the second rising edge after the edge that accepts the sample. The bench stamps each expected entry with that edge's index and compares at the falling edge that follows it. In every other cycle it requires `out_valid` low. This means a result that comes early, comes late or is missing is reported as well as a wrong value. The expected differences come from separate per-channel reference delay lines kept in the bench.

// File: rtl/mc_comb_pkg.sv
package mc_comb_pkg;
  localparam int DEF_NUM_CH = 4;
  localparam int DEF_DLY    = 2;
  localparam int DEF_DW     = 12;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mc_comb_ptr.sv
module mc_comb_ptr #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr;
    if (adv) ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end
endmodule

// File: rtl/mc_comb_ram.sv
module mc_comb_ram #(
  parameter int DW    = 12,
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PTR_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] seen;
  logic [DW-1:0]    rd_nxt;

  // Storage array: no reset, written on every accepted sample.
  always_ff @(posedge clk) begin
    if (en) mem[addr] <= wdata;
  end

  // One "written since reset" flag per slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_seen
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             seen[g] <= 1'b0;
      else if (en && (addr == PTR_W'(g)))     seen[g] <= 1'b1;
    end
  end

  // Read-before-write: the old word of the slot is returned.
  always_comb rd_nxt = seen[addr] ? mem[addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (en) rdata <= rd_nxt;
  end
endmodule

// File: rtl/mc_comb_sub.sv
module mc_comb_sub #(
  parameter int DW   = 12,
  parameter int CH_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DW-1:0]     cur_i,
  input  logic [DW-1:0]     old_i,
  output logic              vld_o,
  output logic [CH_W-1:0]   ch_o,
  output logic signed [DW:0] diff_o
);
  logic signed [DW:0] diff_nxt;

  always_comb diff_nxt = $signed({cur_i[DW-1], cur_i}) - $signed({old_i[DW-1], old_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      ch_o   <= '0;
      diff_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        ch_o   <= ch_i;
        diff_o <= diff_nxt;
      end
    end
  end
endmodule

// File: rtl/mc_comb_delay.sv
module mc_comb_delay
  import mc_comb_pkg::*;
#(
  parameter  int NUM_CH = DEF_NUM_CH,
  parameter  int DLY    = DEF_DLY,
  parameter  int DW     = DEF_DW,
  localparam int CH_W   = idx_width(NUM_CH),
  localparam int DEPTH  = NUM_CH * DLY,
  localparam int PTR_W  = idx_width(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [CH_W-1:0]    in_ch,
  input  logic signed [DW-1:0] in_sample,
  output logic               out_valid,
  output logic [CH_W-1:0]    out_ch,
  output logic signed [DW:0] out_diff
);
  logic [PTR_W-1:0] ptr;
  logic [DW-1:0]    old_q;
  logic             s1_vld;
  logic [CH_W-1:0]  s1_ch;
  logic [DW-1:0]    s1_smp;

  mc_comb_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .ptr(ptr)
  );

  // Read slot = write slot - DEPTH (mod DEPTH) = write slot.
  mc_comb_ram #(.DW(DW), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .addr(ptr),
    .wdata(in_sample), .rdata(old_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_ch  <= '0;
      s1_smp <= '0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_ch  <= in_ch;
        s1_smp <= in_sample;
      end
    end
  end

  mc_comb_sub #(.DW(DW), .CH_W(CH_W)) u_sub (
    .clk(clk), .rst_n(rst_n), .vld_i(s1_vld), .ch_i(s1_ch),
    .cur_i(s1_smp), .old_i(old_q),
    .vld_o(out_valid), .ch_o(out_ch), .diff_o(out_diff)
  );
endmodule

// File: rtl/mc_comb_chk.sv
module mc_comb_chk #(
  parameter int CH_W  = 2,
  parameter int PTR_W = 3,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [CH_W-1:0]  in_ch,
  input logic             out_valid,
  input logic [CH_W-1:0]  out_ch,
  input logic [PTR_W-1:0] wr_ptr
);
  logic [1:0] age;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm = (age >= 2'd2);

  // R8
  no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (warm && $past(in_valid, 2)));

  // R2
  due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2)) |-> out_valid);

  // R2
  ch_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid) |-> (out_ch == $past(in_ch, 2)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(wr_ptr));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (wr_ptr == (($past(wr_ptr) == PTR_W'(DEPTH - 1)) ? '0 : $past(wr_ptr) + 1'b1)));
endmodule

bind mc_comb_delay mc_comb_chk #(.CH_W(CH_W), .PTR_W(PTR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
  .out_valid(out_valid), .out_ch(out_ch), .wr_ptr(ptr)
);

// File: tb/sim_mc_comb_delay.sv
`timescale 1ns/1ps
module sim_mc_comb_delay;
  localparam int NUM_CH = 4;
  localparam int DLY    = 2;
  localparam int DW     = 12;
  localparam int CH_W   = 2;
  localparam int SBN    = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [CH_W-1:0] in_ch = '0;
  logic signed [DW-1:0] in_sample = '0;
  logic out_valid;
  logic [CH_W-1:0] out_ch;
  logic signed [DW:0] out_diff;

  mc_comb_delay #(.NUM_CH(NUM_CH), .DLY(DLY), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
    .in_sample(in_sample), .out_valid(out_valid), .out_ch(out_ch), .out_diff(out_diff)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;
  bit live = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference delay lines
  int hist [NUM_CH][DLY];
  int cnt  [NUM_CH];
  int pos  [NUM_CH];
  int nxt_ch = 0;

  // scoreboard
  int    sb_diff [SBN];
  int    sb_ch   [SBN];
  int    sb_due  [SBN];
  string sb_tag  [SBN];
  int sb_wr = 0;
  int sb_rd = 0;

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic ref_reset();
    for (int c = 0; c < NUM_CH; c++) begin
      cnt[c] = 0; pos[c] = 0;
      for (int k = 0; k < DLY; k++) hist[c][k] = 0;
    end
    nxt_ch = 0;
  endtask

  task automatic push(input int val, input string tag);
    int old;
    @(negedge clk);
    in_valid  = 1'b1;
    in_ch     = CH_W'(nxt_ch);
    in_sample = DW'(val);
    old = (cnt[nxt_ch] >= DLY) ? hist[nxt_ch][pos[nxt_ch]] : 0;
    hist[nxt_ch][pos[nxt_ch]] = val;
    pos[nxt_ch] = (pos[nxt_ch] + 1) % DLY;
    cnt[nxt_ch]++;
    sb_diff[sb_wr % SBN] = val - old;
    sb_ch[sb_wr % SBN]   = nxt_ch;
    sb_due[sb_wr % SBN]  = cyc + 2;
    sb_tag[sb_wr % SBN]  = tag;
    sb_wr++;
    nxt_ch = (nxt_ch + 1) % NUM_CH;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain(input string tag);
    idle(4);
    check(tag, sb_wr - sb_rd, 0);
  endtask

  // result monitor: each expected entry is due at its stamped edge
  always @(negedge clk) begin
    if (live) begin
      if (sb_rd != sb_wr && sb_due[sb_rd % SBN] == cyc) begin
        check("R2", int'(out_valid), 1);
        check("R2", int'(out_ch), sb_ch[sb_rd % SBN]);
        check(sb_tag[sb_rd % SBN], int'(out_diff), sb_diff[sb_rd % SBN]);
        sb_rd++;
      end else begin
        check("R8", int'(out_valid), 0);
      end
    end
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_ch), 0);
    check("R1", int'(out_diff), 0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_reset();
    live = 1;
    idle(2);
    check("R1", int'(out_valid), 0);
  endtask

  task automatic t_fill();
    for (int k = 0; k < NUM_CH * DLY; k++) push(100 + 13 * k - 60 * (k % 3), "R4");
    drain("R4");
  endtask

  task automatic t_ramp();
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < NUM_CH; c++) push(c * 50 + r * 7 - 90, "R3");
    drain("R3");
  endtask

  task automatic t_mix();
    for (int r = 0; r < 5; r++) begin
      push(321, "R7");
      push((r % 2) ? -700 : 700, "R7");
      push(-5 * r * r, "R7");
      push(1000 - 300 * r, "R7");
    end
    drain("R7");
  endtask

  task automatic t_gaps();
    for (int k = 0; k < 3 * NUM_CH; k++) begin
      push(17 * k - 150, "R5");
      idle((k % 3) + 1);
    end
    drain("R5");
  endtask

  task automatic t_extreme();
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < NUM_CH; c++) push(((r / 2) % 2) ? -2048 : 2047, "R6");
    drain("R6");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_ramp();
    t_mix();
    t_gaps();
    t_extreme();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule